// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Sequencer

This block computes C = M^e mod N by scanning the exponent from its least significant bit. It keeps the running result C and the running power P in registers and drives two external Montgomery multiplier channels that share one modulus output. Channel A updates the result and channel B squares the power. Each channel request is a valid/ready handshake. Each response is a valid/ready handshake in which the block raises its ready only while it is waiting for that channel's product. The multiplier may therefore stall a request for any number of cycles, and it may take any number of cycles to return its product.

A host applies base, exponent, an odd modulus, and the conversion constant 2^(2W) mod N, and then pulses start. Entry into Montgomery form uses both channels at once: C becomes R mod N and P becomes M·R mod N. Each of the following h-1 iterations squares P on channel B. When the exponent bit is 1, the same iteration also multiplies C by P on channel A. The top exponent bit gets one conditional multiply with no squaring. A final multiply by 1 on channel A returns C to normal form. Done then pulses for one cycle with the result valid.

Top module: `modexp_ctrl`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 and neither channel raises request valid until start is pulsed.
- R2: For odd N, M < N and conv_r2 = 2^(2W) mod N, result equals M^e mod N in normal form when done is 1.
- R3: In one run, channel B accepts exactly EXP_W requests. One is the entry conversion M×conv_r2, and the others are one squaring P×P for each of bits 0 to EXP_W-2. The top exponent bit gets no squaring.
- R4: In one run, channel A accepts exactly 2 + popcount(e) requests: the entry conversion, one C×P for each exponent bit equal to 1 (the top bit included), and the exit conversion C×1.
- R5: While a request valid is 1 and its ready is 0, on the next cycle valid stays 1 and both request operands are unchanged.
- R6: A start pulse while busy is 1 has no effect. The running computation and its request counts finish unchanged.
- R7: An exponent of 0 returns 1.
- R8: While busy is 1, mul_mod is stable and equals the modulus that was present at start.
- R9: Done is 1 for exactly one cycle, and busy is 0 in the cycle after it.
- R10: In an iteration, C and P are both updated only after both launched products have returned, whatever their order or latency. The squaring therefore always uses the previous P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| base_m | input | W | Base M, below N |
| expo | input | EXP_W | Exponent e |
| modulus | input | W | Odd modulus N |
| conv_r2 | input | W | Conversion constant 2^(2W) mod N |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | C in normal form, valid with done |
| mul_mod | output | W | Modulus shared by both channels |
| a_req_valid | output | 1 | Channel A request valid |
| a_req_ready | input | 1 | Channel A request ready |
| a_req_x | output | W | Channel A first operand |
| a_req_y | output | W | Channel A second operand |
| a_rsp_valid | input | 1 | Channel A product valid |
| a_rsp_ready | output | 1 | Channel A product accepted |
| a_rsp_data | input | W | Channel A product |
| b_req_valid | output | 1 | Channel B request valid |
| b_req_ready | input | 1 | Channel B request ready |
| b_req_x | output | W | Channel B first operand |
| b_req_y | output | W | Channel B second operand |
| b_rsp_valid | input | 1 | Channel B product valid |
| b_rsp_ready | output | 1 | Channel B product accepted |
| b_rsp_data | input | W | Channel B product |

## Verification
The hardest case to reach is an iteration in which the two channel products return in different orders and after different delays. Only that case shows whether C and P wait for each other and whether the squaring uses the previous P. The bench's behavioural multiplier draws the request-ready stalls and the response latency at random, separately for each channel, on every transaction. Over long exponents, channel A finishes first in some iterations and channel B in others. The bench also sends a spurious start with different operands in the middle of a run.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ENT_GO, ST_ENT_W, ST_LOOP_GO, ST_LOOP_W,
    ST_LAST_GO, ST_LAST_W, ST_EXIT_GO, ST_EXIT_W, ST_DONE
  } mexp_state_e;
endpackage

// File: rtl/mexp_mul_chan.sv
// One multiplier channel: holds a request until accepted, then waits for its product.
module mexp_mul_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic         req_valid,
  input  logic         req_ready,
  output logic [W-1:0] req_x,
  output logic [W-1:0] req_y,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [W-1:0] rsp_data,
  output logic         got,
  output logic [W-1:0] prod
);
  logic pend_req, pend_rsp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_req <= 1'b0;
      pend_rsp <= 1'b0;
      got      <= 1'b0;
      prod     <= '0;
      req_x    <= '0;
      req_y    <= '0;
    end else if (launch) begin
      req_x    <= op_x;
      req_y    <= op_y;
      pend_req <= 1'b1;
      got      <= 1'b0;
    end else if (pend_req && req_ready) begin
      pend_req <= 1'b0;
      pend_rsp <= 1'b1;
    end else if (pend_rsp && rsp_valid) begin
      pend_rsp <= 1'b0;
      got      <= 1'b1;
      prod     <= rsp_data;
    end
  end

  assign req_valid = pend_req;
  assign rsp_ready = pend_rsp;
endmodule

// File: rtl/mexp_scan.sv
// Exponent scanner: presents bit i, advances on step, flags the last loop iteration.
module mexp_scan #(
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXP_W-1:0] e_in,
  input  logic             step,
  output logic             bit_now,
  output logic             loop_end
);
  localparam int IW = (EXP_W > 2) ? $clog2(EXP_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(EXP_W - 2);

  logic [EXP_W-1:0] sh;
  logic [IW-1:0]    idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= e_in;
      idx <= '0;
    end else if (step) begin
      sh  <= {1'b0, sh[EXP_W-1:1]};
      idx <= idx + 1'b1;
    end
  end

  assign bit_now  = sh[0];
  assign loop_end = (idx == LAST_IDX);
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl #(
  parameter int W     = 16,
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     base_m,
  input  logic [EXP_W-1:0] expo,
  input  logic [W-1:0]     modulus,
  input  logic [W-1:0]     conv_r2,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result,
  output logic [W-1:0]     mul_mod,
  output logic             a_req_valid,
  input  logic             a_req_ready,
  output logic [W-1:0]     a_req_x,
  output logic [W-1:0]     a_req_y,
  input  logic             a_rsp_valid,
  output logic             a_rsp_ready,
  input  logic [W-1:0]     a_rsp_data,
  output logic             b_req_valid,
  input  logic             b_req_ready,
  output logic [W-1:0]     b_req_x,
  output logic [W-1:0]     b_req_y,
  input  logic             b_rsp_valid,
  output logic             b_rsp_ready,
  input  logic [W-1:0]     b_rsp_data
);
  import mexp_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  mexp_state_e st;
  logic [W-1:0] c_reg, p_reg, n_reg, r2_reg;
  logic         use_a;

  logic         launch_a, launch_b;
  logic [W-1:0] ax, ay, bx, by;
  logic         a_got, b_got;
  logic [W-1:0] a_prod, b_prod;
  logic         scan_load, scan_step, cur_bit, loop_end;
  logic         pair_ready;

  // Operand selection and launch decisions per state
  always_comb begin
    launch_a = 1'b0;
    launch_b = 1'b0;
    ax = c_reg;
    ay = p_reg;
    bx = p_reg;
    by = p_reg;
    unique case (st)
      ST_ENT_GO: begin
        launch_a = 1'b1;  ax = r2_reg; ay = ONE;
        launch_b = 1'b1;  bx = p_reg;  by = r2_reg;
      end
      ST_LOOP_GO: begin
        launch_a = cur_bit;
        launch_b = 1'b1;
      end
      ST_LAST_GO: launch_a = cur_bit;
      ST_EXIT_GO: begin
        launch_a = 1'b1;  ay = ONE;
      end
      default: ;
    endcase
  end

  assign pair_ready = (!use_a || a_got) && b_got;
  assign scan_load  = (st == ST_IDLE) && start;
  assign scan_step  = (st == ST_LOOP_W) && pair_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      c_reg  <= '0;
      p_reg  <= '0;
      n_reg  <= '0;
      r2_reg <= '0;
      use_a  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          p_reg  <= base_m;
          n_reg  <= modulus;
          r2_reg <= conv_r2;
          st     <= ST_ENT_GO;
        end
        ST_ENT_GO: begin
          use_a <= 1'b1;
          st    <= ST_ENT_W;
        end
        ST_ENT_W: if (pair_ready) begin
          c_reg <= a_prod;
          p_reg <= b_prod;
          st    <= ST_LOOP_GO;
        end
        ST_LOOP_GO: begin
          use_a <= cur_bit;
          st    <= ST_LOOP_W;
        end
        ST_LOOP_W: if (pair_ready) begin
          if (use_a) c_reg <= a_prod;
          p_reg <= b_prod;
          st    <= loop_end ? ST_LAST_GO : ST_LOOP_GO;
        end
        ST_LAST_GO: st <= cur_bit ? ST_LAST_W : ST_EXIT_GO;
        ST_LAST_W: if (a_got) begin
          c_reg <= a_prod;
          st    <= ST_EXIT_GO;
        end
        ST_EXIT_GO: st <= ST_EXIT_W;
        ST_EXIT_W: if (a_got) begin
          c_reg <= a_prod;
          st    <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  mexp_scan #(.EXP_W(EXP_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(scan_load), .e_in(expo),
    .step(scan_step), .bit_now(cur_bit), .loop_end(loop_end)
  );

  mexp_mul_chan #(.W(W)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .launch(launch_a), .op_x(ax), .op_y(ay),
    .req_valid(a_req_valid), .req_ready(a_req_ready), .req_x(a_req_x), .req_y(a_req_y),
    .rsp_valid(a_rsp_valid), .rsp_ready(a_rsp_ready), .rsp_data(a_rsp_data),
    .got(a_got), .prod(a_prod)
  );

  mexp_mul_chan #(.W(W)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .launch(launch_b), .op_x(bx), .op_y(by),
    .req_valid(b_req_valid), .req_ready(b_req_ready), .req_x(b_req_x), .req_y(b_req_y),
    .rsp_valid(b_rsp_valid), .rsp_ready(b_rsp_ready), .rsp_data(b_rsp_data),
    .got(b_got), .prod(b_prod)
  );

  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_DONE);
  assign result  = c_reg;
  assign mul_mod = n_reg;
endmodule

// File: rtl/mexp_chk.sv
module mexp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] mul_mod,
  input logic         a_req_valid,
  input logic         a_req_ready,
  input logic [W-1:0] a_req_x,
  input logic [W-1:0] a_req_y,
  input logic         b_req_valid,
  input logic         b_req_ready,
  input logic [W-1:0] b_req_x,
  input logic [W-1:0] b_req_y
);
  // R5
  a_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_req_valid && !a_req_ready |=> a_req_valid && $stable(a_req_x) && $stable(a_req_y));
  // R5
  b_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_req_valid && !b_req_ready |=> b_req_valid && $stable(b_req_x) && $stable(b_req_y));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !a_req_valid && !b_req_valid);
  // R8
  mod_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mul_mod));
endmodule

bind modexp_ctrl mexp_chk #(.W(W)) u_mexp_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mul_mod(mul_mod),
  .a_req_valid(a_req_valid), .a_req_ready(a_req_ready), .a_req_x(a_req_x), .a_req_y(a_req_y),
  .b_req_valid(b_req_valid), .b_req_ready(b_req_ready), .b_req_x(b_req_x), .b_req_y(b_req_y)
);

// File: tb/modexp_ctrl_bench.sv
module modexp_ctrl_bench;
  localparam int W = 16;
  localparam int EXP_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] base_m = '0, modulus = '0, conv_r2 = '0;
  logic [EXP_W-1:0] expo = '0;
  logic busy, done;
  logic [W-1:0] result, mul_mod;
  logic a_req_valid, a_req_ready, a_rsp_valid, a_rsp_ready;
  logic b_req_valid, b_req_ready, b_rsp_valid, b_rsp_ready;
  logic [W-1:0] a_req_x, a_req_y, a_rsp_data, b_req_x, b_req_y, b_rsp_data;

  always #2.5 clk = ~clk;

  modexp_ctrl #(.W(W), .EXP_W(EXP_W)) u_modexp_ctrl (.*);

  int checks = 0, fails = 0;
  int a_cnt = 0, b_cnt = 0;
  logic [W-1:0] q_res[$], q_mod[$];
  int q_a[$], q_b[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mont(input logic [63:0] a, input logic [63:0] b, input logic [63:0] n);
    logic [63:0] t = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i]) t = t + b;
      if (t[0]) t = t + n;
      t = t >> 1;
    end
    if (t >= n) t = t - n;
    return t;
  endfunction

  function automatic logic [63:0] ref_pow(input logic [63:0] m, input logic [63:0] e, input logic [63:0] n);
    logic [63:0] r = 1 % n, b = m % n;
    for (int i = 0; i < EXP_W; i++) begin
      if (e[i]) r = (r * b) % n;
      b = (b * b) % n;
    end
    return r;
  endfunction

  // Behavioural multiplier, channel A
  initial begin : model_a
    bit acc = 0, dlv = 0;
    int cnt = 0;
    logic [W-1:0] val = '0;
    a_req_ready = 0; a_rsp_valid = 0; a_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (acc) begin acc = 0; a_req_ready = 0; cnt = $urandom_range(4, 1); end
      else if (dlv) begin dlv = 0; a_rsp_valid = 0; end
      else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin a_rsp_valid = 1; a_rsp_data = val; if (a_rsp_ready) dlv = 1; end
      end else if (a_rsp_valid) begin if (a_rsp_ready) dlv = 1; end
      else begin
        a_req_ready = a_req_valid && ($urandom_range(1, 0) == 1);
        if (a_req_ready) begin
          acc = 1; a_cnt++;
          val = W'(mont(64'(a_req_x), 64'(a_req_y), 64'(mul_mod)));
        end
      end
    end
  end

  // Behavioural multiplier, channel B
  initial begin : model_b
    bit acc = 0, dlv = 0;
    int cnt = 0;
    logic [W-1:0] val = '0;
    b_req_ready = 0; b_rsp_valid = 0; b_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (acc) begin acc = 0; b_req_ready = 0; cnt = $urandom_range(4, 1); end
      else if (dlv) begin dlv = 0; b_rsp_valid = 0; end
      else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin b_rsp_valid = 1; b_rsp_data = val; if (b_rsp_ready) dlv = 1; end
      end else if (b_rsp_valid) begin if (b_rsp_ready) dlv = 1; end
      else begin
        b_req_ready = b_req_valid && ($urandom_range(1, 0) == 1);
        if (b_req_ready) begin
          acc = 1; b_cnt++;
          val = W'(mont(64'(b_req_x), 64'(b_req_y), 64'(mul_mod)));
        end
      end
    end
  end

  // Monitor: pops expectations when done is seen
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done) begin
        if (q_res.size() == 0) check(0, "R9 unexpected done", 1, 0);
        else begin
          logic [W-1:0] er, em;
          int ea, eb;
          er = q_res.pop_front(); em = q_mod.pop_front();
          ea = q_a.pop_front();  eb = q_b.pop_front();
          check(result == er, "R2/R7/R10 result", result, er);
          check(a_cnt == ea, "R4 channel A requests", a_cnt, ea);
          check(b_cnt == eb, "R3 channel B requests", b_cnt, eb);
          check(mul_mod == em, "R8 modulus", mul_mod, em);
          @(negedge clk);
          check(!done && !busy, "R9 done width", {done, busy}, 0);
        end
      end
    end
  end

  task automatic run_case(input logic [W-1:0] m, input logic [EXP_W-1:0] e,
                          input logic [W-1:0] n, input bit spur);
    while (busy) @(negedge clk);
    q_res.push_back(W'(ref_pow(64'(m), 64'(e), 64'(n))));
    q_mod.push_back(n);
    q_a.push_back(2 + $countones(e));
    q_b.push_back(EXP_W);
    a_cnt = 0; b_cnt = 0;
    base_m = m; expo = e; modulus = n;
    conv_r2 = W'((64'd1 << (2 * W)) % 64'(n));
    start = 1;
    @(negedge clk);
    start = 0;
    if (spur) begin
      // R6: a second start with different operands while busy
      repeat (7) @(negedge clk);
      base_m = 16'd5; expo = 16'h00F0; modulus = 16'd9; conv_r2 = 16'd7;
      start = 1;
      @(negedge clk);
      start = 0;
      check(busy, "R6 still busy after spurious start", busy, 1);
    end
    while (q_res.size() > 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done, "R1 reset outputs", {busy, done}, 0);
    check(!a_req_valid && !b_req_valid, "R1 no requests in reset", {a_req_valid, b_req_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!busy && !a_req_valid && !b_req_valid, "R1 idle after reset", busy, 0);

    run_case(16'd7,     16'h0000, 16'd13,    0);  // R7 zero exponent
    run_case(16'd1234,  16'h0001, 16'd40961, 0);
    run_case(16'd2,     16'h8000, 16'd65521, 0);  // only top bit
    run_case(16'd65000, 16'hFFFF, 16'd65521, 0);  // every bit set
    run_case(16'd0,     16'h0135, 16'd999,   0);
    run_case(16'd3,     16'hA5C3, 16'd1001,  1);  // R6 spurious start
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] n = W'($urandom_range(65535, 3)) | 16'd1;
      run_case(W'($urandom_range(32'(n) - 1, 0)), EXP_W'($urandom), n, k[0]);
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule